// File: doc/BRIEF.md
# Vectored Latched Interrupt Controller

This block sits beside a small 8-bit processor core and turns five interrupt request lines into a single vector request. One line is non-maskable. The other four are maskable. Two of them come from port pins. One gathers a timer flag and a converter end-of-conversion flag, each gated by its own enable. The last one carries any other peripheral flag. Requests from pins pass through a synchronizer. Edge-detected events are held in latches, so an event that arrives while maskable interrupts are globally off is not lost. The event is serviced as soon as the global enable is set.

The controller picks the highest-priority request that is eligible. It presents the index of that request and a vector address, which the core loads into its program counter. When the core accepts the request it pulses an acknowledge. That pulse clears the latch of the accepted source and marks a routine as active. While a routine is active, further requests of the same class are blocked until the core pulses a return input. A wake output tells the stop/wait logic that something is pending.

Top module: `lvi_top`

## Requirements
- R1: While and directly after reset, `irq_req` is 0, `wake` is 0 and no routine is active, provided all request inputs are low.
- R2: A rising edge on `nmi_pin` is latched as source index 0 and is requested whatever `glob_en` is. Once index 0 is acknowledged, it is not requested again until `irq_ret` ends its routine.
- R3: Maskable sources (indices 1 to 4) are requested only while `glob_en` is 1. An edge event that arrives while `glob_en` is 0 stays latched and is requested once `glob_en` becomes 1.
- R4: Fixed priority applies: index 0 > 1 > 2 > 3 > 4. Index 1 is `pin_a`, index 2 is `pin_b`, index 3 is the timer/converter group and index 4 is `aux_flag`. `vec_idx` shows the winner.
- R5: `vec_addr` equals `VEC_BASE + 2 * vec_idx` (default base 0x3F0).
- R6: An acknowledge (`irq_ack` high while `irq_req` is high) clears the latch of the accepted source when that index is 0, 1 or 2. A new edge on the same line in the same cycle keeps the latch set. An acknowledge while `irq_req` is 0 has no effect.
- R7: Index 3 is pending while `(tmr_flag & tmr_ie) | (cnv_flag & cnv_ie)` is 1. It follows these levels in the same cycle and is not cleared by an acknowledge.
- R8: With `pin_a_edge` = 1, a synchronized rising edge of `pin_a` sets its latch. With `pin_a_edge` = 0, index 1 follows the synchronized `pin_a` level, and its latch is held clear.
- R9: After a maskable acknowledge, indices 1 to 4 are blocked until `irq_ret`. Index 0 can still be accepted during that time.
- R10: `wake` is 1 whenever any source is pending after the per-source enables, regardless of `glob_en` or active routines.
- R11: An edge on a synchronized pin becomes visible at the outputs after the third rising clock edge. A level-mode `pin_a` becomes visible after the second edge. Peripheral flags take effect in the same cycle.
- R12: While the non-maskable routine is active, nothing is requested. `irq_ret` ends the non-maskable routine first if it is active; otherwise it ends the maskable routine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_pin | input | 1 | Non-maskable request pin (asynchronous) |
| pin_a | input | 1 | Port interrupt line A (asynchronous) |
| pin_b | input | 1 | Port interrupt line B (asynchronous) |
| pin_a_edge | input | 1 | 1 selects edge detection for line A, 0 selects level |
| tmr_flag | input | 1 | Timer event flag |
| tmr_ie | input | 1 | Timer source enable |
| cnv_flag | input | 1 | Converter end-of-conversion flag |
| cnv_ie | input | 1 | Converter source enable |
| aux_flag | input | 1 | Other peripheral flag line |
| glob_en | input | 1 | Global maskable enable |
| irq_ack | input | 1 | Core accepts the presented vector |
| irq_ret | input | 1 | Core returns from a routine |
| irq_req | output | 1 | A vector is presented |
| vec_idx | output | 3 | Index of the presented source |
| vec_addr | output | ADDR_W | Vector address for the program counter |
| wake | output | 1 | Something is pending; ends stop or wait |

## Verification
Each result has a due cycle counted from its stimulus. A pin edge must reach the outputs at the third rising edge after it is driven. A level-mode pin must reach them at the second edge. Flag and enable changes must show in the same cycle. Acknowledge and return effects must show one edge later.

The bench drives inputs just after a falling edge. Its reference model advances on each rising edge, using the inputs and its own state from before that edge. At every falling edge it compares all four outputs with the model. Directed checks then confirm the boundary cycles, for example that an edge is absent after two edges and present after three.

// File: rtl/lvi_pkg.sv
package lvi_pkg;

    localparam int NSRC  = 5;
    localparam int IDX_W = $clog2(NSRC);
    localparam int NLAT  = 3;

    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [IDX_W-1:0] {
        SRC_NMI    = 3'd0,
        SRC_PIN_A  = 3'd1,
        SRC_PIN_B  = 3'd2,
        SRC_PERIPH = 3'd3,
        SRC_AUX    = 3'd4
    } src_e;

    typedef struct packed {
        logic valid;
        idx_t idx;
    } pick_t;

    typedef struct packed {
        logic nmi;
        logic mask;
    } busy_t;

    function automatic logic [15:0] vec_offset(idx_t i);
        return 16'(i) << 1;
    endfunction

endpackage

// File: rtl/lvi_sync.sv
module lvi_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [STAGES:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= din;
            for (int s = 1; s <= STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/lvi_latch.sv
module lvi_latch #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr) | set;
    end
endmodule

// File: rtl/lvi_pick.sv
module lvi_pick
    import lvi_pkg::*;
(
    input  logic [NSRC-1:0] elig,
    output pick_t           win
);
    always_comb begin
        win = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                win.valid = 1'b1;
                win.idx   = idx_t'(i);
            end
        end
    end
endmodule

// File: rtl/lvi_top.sv
module lvi_top
    import lvi_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter int                STAGES   = 2,
    parameter logic [ADDR_W-1:0] VEC_BASE = 12'h3F0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nmi_pin,
    input  logic              pin_a,
    input  logic              pin_b,
    input  logic              pin_a_edge,
    input  logic              tmr_flag,
    input  logic              tmr_ie,
    input  logic              cnv_flag,
    input  logic              cnv_ie,
    input  logic              aux_flag,
    input  logic              glob_en,
    input  logic              irq_ack,
    input  logic              irq_ret,
    output logic              irq_req,
    output logic [IDX_W-1:0]  vec_idx,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              wake
);
    logic [NLAT-1:0] pin_lvl, pin_rise;
    logic [NLAT-1:0] lat_set, lat_clr, lat_q, acc_hit;
    logic [NSRC-1:0] pend, elig;
    pick_t           sel;
    busy_t           busy, busy_nx;
    logic            accept;
    logic            mask_busy, nmi_busy;

    lvi_sync #(.W(NLAT), .STAGES(STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({pin_b, pin_a, nmi_pin}),
        .lvl (pin_lvl),
        .rise(pin_rise)
    );

    assign lat_set = {pin_rise[2], pin_rise[1] & pin_a_edge, pin_rise[0]};

    for (genvar c = 0; c < NLAT; c++) begin : g_clr
        assign acc_hit[c] = accept && (sel.idx == idx_t'(c));
    end

    assign lat_clr = acc_hit | {1'b0, ~pin_a_edge, 1'b0};

    lvi_latch #(.W(NLAT)) u_lat (
        .clk(clk),
        .rst(rst),
        .set(lat_set),
        .clr(lat_clr),
        .q  (lat_q)
    );

    always_comb begin
        pend             = '0;
        pend[SRC_NMI]    = lat_q[0];
        pend[SRC_PIN_A]  = pin_a_edge ? lat_q[1] : pin_lvl[1];
        pend[SRC_PIN_B]  = lat_q[2];
        pend[SRC_PERIPH] = (tmr_flag & tmr_ie) | (cnv_flag & cnv_ie);
        pend[SRC_AUX]    = aux_flag;
    end

    always_comb begin
        elig = '0;
        elig[SRC_NMI] = pend[SRC_NMI] & ~busy.nmi;
        for (int k = 1; k < NSRC; k++) begin
            elig[k] = pend[k] & glob_en & ~busy.mask & ~busy.nmi;
        end
    end

    lvi_pick u_pick (
        .elig(elig),
        .win (sel)
    );

    assign accept = irq_ack & sel.valid;

    always_comb begin
        busy_nx = busy;
        if (irq_ret) begin
            if (busy.nmi) busy_nx.nmi  = 1'b0;
            else          busy_nx.mask = 1'b0;
        end
        if (accept) begin
            if (sel.idx == SRC_NMI) busy_nx.nmi  = 1'b1;
            else                    busy_nx.mask = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) busy <= '0;
        else     busy <= busy_nx;
    end

    assign mask_busy = busy.mask;
    assign nmi_busy  = busy.nmi;

    assign irq_req  = sel.valid;
    assign vec_idx  = sel.idx;
    assign vec_addr = VEC_BASE + ADDR_W'(vec_offset(sel.idx));
    assign wake     = |pend;
endmodule

// File: rtl/lvi_checks.sv
module lvi_checks
    import lvi_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             glob_en,
    input logic             irq_ack,
    input logic             irq_req,
    input logic [IDX_W-1:0] vec_idx,
    input logic             wake,
    input logic             mask_busy,
    input logic             nmi_busy
);
    AST_NMI_SELF_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req && vec_idx == 3'd0) |=> !(irq_req && vec_idx == 3'd0)); // R2
    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (rst)
        (irq_req && vec_idx != 3'd0) |-> glob_en); // R3
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (vec_idx < 3'(NSRC))); // R4
    AST_MASK_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req && vec_idx != 3'd0) |=> mask_busy); // R9
    AST_MASK_BUSY_NMI_ONLY: assert property (@(posedge clk) disable iff (rst)
        (mask_busy && irq_req) |-> vec_idx == 3'd0); // R9
    AST_WAKE_COVER: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> wake); // R10
    AST_NMI_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
        nmi_busy |-> !irq_req); // R12
endmodule

bind lvi_top lvi_checks u_chk (
    .clk      (clk),
    .rst      (rst),
    .glob_en  (glob_en),
    .irq_ack  (irq_ack),
    .irq_req  (irq_req),
    .vec_idx  (vec_idx),
    .wake     (wake),
    .mask_busy(mask_busy),
    .nmi_busy (nmi_busy)
);

// File: tb/lvi_top_bench.sv
module lvi_top_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nmi_pin = 0, pin_a = 0, pin_b = 0, pin_a_edge = 1;
    logic tmr_flag = 0, tmr_ie = 0, cnv_flag = 0, cnv_ie = 0, aux_flag = 0;
    logic glob_en = 0, irq_ack = 0, irq_ret = 0;
    logic        irq_req, wake;
    logic [2:0]  vec_idx;
    logic [11:0] vec_addr;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 0;
    string tag   = "R1";

    lvi_top u_lvi_top (.*);

    always #2.5 clk = ~clk;

    // behavioural reference state
    bit s1[3], s2[3], s3[3];
    bit lat[3];
    bit m_nb, m_mb;

    function automatic bit src_pend(int i);
        case (i)
            0: return lat[0];
            1: return pin_a_edge ? lat[1] : s2[1];
            2: return lat[2];
            3: return (tmr_flag && tmr_ie) || (cnv_flag && cnv_ie);
            default: return aux_flag;
        endcase
    endfunction

    function automatic int m_pick();
        if (src_pend(0) && !m_nb) return 0;
        for (int i = 1; i < 5; i++)
            if (src_pend(i) && glob_en && !m_mb && !m_nb) return i;
        return -1;
    endfunction

    function automatic bit m_wake();
        for (int i = 0; i < 5; i++) if (src_pend(i)) return 1'b1;
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 3; i++) begin
                s1[i] = 0; s2[i] = 0; s3[i] = 0; lat[i] = 0;
            end
            m_nb = 0; m_mb = 0;
        end else begin
            int  w;
            bit  nb_n, mb_n;
            bit  rs[3];
            w    = m_pick();
            nb_n = m_nb;
            mb_n = m_mb;
            if (irq_ret) begin
                if (m_nb) nb_n = 0; else mb_n = 0;
            end
            if (irq_ack && w >= 0) begin
                if (w == 0) nb_n = 1; else mb_n = 1;
                if (w < 3) lat[w] = 0;
            end
            for (int i = 0; i < 3; i++) rs[i] = s2[i] && !s3[i];
            if (rs[0]) lat[0] = 1;
            if (rs[2]) lat[2] = 1;
            if (!pin_a_edge) lat[1] = 0;
            else if (rs[1]) lat[1] = 1;
            m_nb = nb_n;
            m_mb = mb_n;
            for (int i = 0; i < 3; i++) begin
                s3[i] = s2[i]; s2[i] = s1[i];
            end
            s1[0] = nmi_pin; s1[1] = pin_a; s1[2] = pin_b;
        end
    end

    task automatic chk(string t, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
        end
    endtask

    task automatic step(int n);
        for (int k = 0; k < n; k++) begin
            int w;
            @(negedge clk);
            w = m_pick();
            chk(tag, int'(irq_req), int'(w >= 0), "irq_req");
            chk("R10", int'(wake), int'(m_wake()), "wake");
            if (w >= 0) begin
                chk(tag, int'(vec_idx), w, "vec_idx");
                chk("R5", int'(vec_addr), 'h3F0 + 2 * w, "vec_addr");
            end
        end
    endtask

    task automatic ack();
        irq_ack = 1; step(1); irq_ack = 0;
    endtask

    task automatic ret();
        irq_ret = 1; step(1); irq_ret = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 0;
        step(1);
        chk("R1", int'(irq_req), 0, "req after reset");
        chk("R1", int'(wake), 0, "wake after reset");

        // R2 / R11: nmi edge timing, taken while glob_en = 0
        tag = "R2";
        nmi_pin = 1; step(2);
        chk("R11", int'(irq_req), 0, "nmi after 2 edges");
        nmi_pin = 0; step(1);
        chk("R11", int'(irq_req), 1, "nmi after 3 edges");
        chk("R2", int'(vec_idx), 0, "nmi index");
        ack();
        chk("R12", int'(irq_req), 0, "nmi routine active");
        nmi_pin = 1; step(2); nmi_pin = 0; step(3);
        chk("R2", int'(irq_req), 0, "second nmi blocked");
        ret();
        chk("R2", int'(irq_req), 1, "second nmi after return");
        ack(); ret();

        // R3: event while disabled is kept
        tag = "R3";
        pin_b = 1; step(2); pin_b = 0; step(3);
        chk("R3", int'(irq_req), 0, "masked while disabled");
        chk("R10", int'(wake), 1, "wake while disabled");
        glob_en = 1; step(1);
        chk("R3", int'(vec_idx), 2, "served after enable");
        ack();
        chk("R6", int'(wake), 0, "latch cleared by ack");
        ret();

        // R6: ack with no request does nothing
        tag = "R6";
        ack();
        aux_flag = 1; step(1);
        chk("R6", int'(vec_idx), 4, "stray ack ignored");
        aux_flag = 0;

        // R7: peripheral group with enables
        tag = "R7";
        tmr_flag = 1; step(1);
        chk("R7", int'(wake), 0, "timer disabled");
        tmr_ie = 1; step(1);
        chk("R7", int'(vec_idx), 3, "timer enabled");
        ack(); ret();
        chk("R7", int'(irq_req), 1, "level kept after ack");
        tmr_flag = 0; cnv_flag = 1; cnv_ie = 1; step(1);
        chk("R7", int'(vec_idx), 3, "converter on same vector");
        cnv_flag = 0; step(1);

        // R4 / R9: priority and maskable busy
        tag = "R4";
        aux_flag = 1; tmr_flag = 1; pin_b = 1; pin_a = 1;
        step(3);
        chk("R4", int'(vec_idx), 1, "pin_a wins");
        pin_a = 0; pin_b = 0;
        ack();
        chk("R9", int'(irq_req), 0, "maskable blocked");
        tag = "R9";
        nmi_pin = 1; step(2); nmi_pin = 0; step(1);
        chk("R9", int'(vec_idx), 0, "nmi during maskable routine");
        ack();
        tag = "R12";
        ret();
        chk("R12", int'(irq_req), 0, "first return ends nmi only");
        ret();
        chk("R4", int'(vec_idx), 2, "pin_b next");
        tag = "R4";
        ack(); ret();
        chk("R4", int'(vec_idx), 3, "periph next");
        tmr_flag = 0; step(1);
        chk("R4", int'(vec_idx), 4, "aux last");
        aux_flag = 0; step(1);

        // R8: level mode for pin_a
        tag = "R8";
        pin_a_edge = 0; pin_a = 1; step(1);
        chk("R11", int'(irq_req), 0, "level after 1 edge");
        step(1);
        chk("R8", int'(vec_idx), 1, "level after 2 edges");
        ack(); ret();
        chk("R8", int'(irq_req), 1, "level stays");
        pin_a = 0; step(2);
        chk("R8", int'(irq_req), 0, "level dropped");
        pin_a_edge = 1; step(4);
        chk("R8", int'(wake), 0, "no stale latch");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule